// File: doc/BRIEF.md
# Early-Out Magnitude Comparator

This block compares two unsigned 32-bit operands and reports whether they are equal, or which one is smaller. Its latency depends on the data. A short check looks only at the lowest four bits of both operands. A full-width check runs beside it. In equality-only mode, a difference in those low bits proves that the operands are unequal, so the result is returned after one cycle instead of three. Loop counters and similar values, which usually differ near the bottom, therefore tend to finish early. When the low bits match, or when magnitude ordering is asked for, the full-width result is used after the longer delay.

A caller presents a request with `req_valid` while `req_ready` is high. Completion is marked by a single-cycle `done` pulse, and the result flags are held steady until the next completion. A new request may be presented in the same cycle that `done` is high. The same structure fits a tag-match use, where only equality matters.

Top module: `early_out_cmp`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `done` is 0, `req_ready` is 1, and `res_eq`, `res_lt`, `res_gt` and `res_early` are 0.
- R2: `req_ready` is low from the cycle after a request is accepted until the cycle in which its `done` is high. A `req_valid` presented while `req_ready` is low is ignored: it produces no `done` and does not change the pending result.
- R3: In equality-only mode (`mag_mode`=0), when bits 3:0 of the operands differ, `done` is high exactly 1 cycle after the accepting clock edge, with `res_eq`=0, `res_lt`=0, `res_gt`=0 and `res_early`=1.
- R4: In equality-only mode, when bits 3:0 of the operands are equal, `done` is high exactly 3 cycles after the accepting edge, with `res_eq` = (A==B), `res_lt`=0, `res_gt`=0 and `res_early`=0.
- R5: In magnitude mode (`mag_mode`=1), `done` is always high exactly 3 cycles after the accepting edge, with `res_early`=0 and exactly one of `res_eq`, `res_lt` (A<B) and `res_gt` (A>B) set. This holds even when the low bits differ.
- R6: Each accepted request produces exactly one `done`, and `done` is never high for two consecutive cycles.
- R7: The result flags change only at the edge that raises `done`, and they hold their values at all other times.
- R8: A request presented in the cycle where `done` is high is accepted at the next edge. Two back-to-back fast requests therefore complete 2 cycles apart, and two back-to-back full requests complete 4 cycles apart.
- R9: The ordering is unsigned: an operand with bit 31 set ranks above any operand with bit 31 clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Comparator idle; a request is taken at the next edge |
| mag_mode | input | 1 | 0: equality only (early exit allowed); 1: magnitude ordering |
| op_a | input | 32 | Operand A |
| op_b | input | 32 | Operand B |
| done | output | 1 | One-cycle completion pulse |
| res_eq | output | 1 | A equals B |
| res_lt | output | 1 | A below B (magnitude mode only) |
| res_gt | output | 1 | A above B (magnitude mode only) |
| res_early | output | 1 | Result came from the low-bit shortcut |

## Verification
The bench targets operand pairs that differ only in the low nibble and pairs that differ only above it. A design that picks the wrong path would either return a full-width answer late, or wrongly report equality early with the wrong latency. Magnitude requests whose low bits differ must not take the shortcut: a design that lets them exit early would report no ordering after one cycle. Pairs with bit 31 set on one side catch a signed comparison, which gives the ordering backwards. Requests held asserted while the comparator is busy, and requests sent back to back in the `done` cycle, expose a design that accepts work it should ignore or that loses a cycle between requests.

// File: rtl/cmp_pkg.sv
package cmp_pkg;

    // result flags delivered with each completion
    typedef struct packed {
        logic eq;
        logic lt;
        logic gt;
        logic early;
    } cmp_res_t;

    localparam cmp_res_t CMP_RES_CLEAR = '{eq: 1'b0, lt: 1'b0, gt: 1'b0, early: 1'b0};

endpackage

// File: rtl/cmp_fast_diff.sv
// Low-slice difference detector: flags any mismatch among the few lowest bits.
module cmp_fast_diff #(
    parameter int FAST_W = 4
) (
    input  logic [FAST_W-1:0] lo_a,
    input  logic [FAST_W-1:0] lo_b,
    output logic              differ
);

    logic [FAST_W-1:0] bit_mismatch;

    for (genvar gi = 0; gi < FAST_W; gi++) begin : g_bit
        assign bit_mismatch[gi] = lo_a[gi] ^ lo_b[gi];
    end

    assign differ = |bit_mismatch;

endmodule

// File: rtl/cmp_full_mag.sv
// Full-width unsigned ordering built from per-chunk compares merged MSB first.
module cmp_full_mag #(
    parameter int DATA_W  = 32,
    parameter int CHUNK_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] full_a,
    input  logic [DATA_W-1:0] full_b,
    output logic              is_eq,
    output logic              is_lt,
    output logic              is_gt
);

    localparam int N_CHUNK = (DATA_W + CHUNK_W - 1) / CHUNK_W;
    localparam int PAD_W   = N_CHUNK * CHUNK_W;

    logic [PAD_W-1:0]   pad_a;
    logic [PAD_W-1:0]   pad_b;
    logic [N_CHUNK-1:0] chunk_lt;
    logic [N_CHUNK-1:0] chunk_gt;

    assign pad_a = PAD_W'(full_a);
    assign pad_b = PAD_W'(full_b);

    for (genvar ci = 0; ci < N_CHUNK; ci++) begin : g_chunk
        logic [CHUNK_W-1:0] seg_a;
        logic [CHUNK_W-1:0] seg_b;
        assign seg_a        = pad_a[ci*CHUNK_W +: CHUNK_W];
        assign seg_b        = pad_b[ci*CHUNK_W +: CHUNK_W];
        assign chunk_lt[ci] = seg_a < seg_b;
        assign chunk_gt[ci] = seg_a > seg_b;
    end

    // the most significant chunk that differs decides the ordering
    always_comb begin
        is_lt = 1'b0;
        is_gt = 1'b0;
        for (int k = N_CHUNK - 1; k >= 0; k--) begin
            if (!is_lt && !is_gt) begin
                is_lt = chunk_lt[k];
                is_gt = chunk_gt[k];
            end
        end
        is_eq = !is_lt && !is_gt;
    end

    // exactly one ordering outcome at all times (R5)
    p_one_order_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot({is_eq, is_lt, is_gt}));

endmodule

// File: rtl/cmp_seq_ctrl.sv
// Latency controller: counts busy cycles, picks the shortcut or the full result,
// emits the done pulse and holds the flags.
module cmp_seq_ctrl
    import cmp_pkg::*;
#(
    parameter int FAST_LAT = 1,
    parameter int FULL_LAT = 3
) (
    input  logic     clk,
    input  logic     rst_n,
    input  logic     start,
    input  logic     mode_mag,
    input  logic     low_differ,
    input  logic     full_eq,
    input  logic     full_lt,
    input  logic     full_gt,
    output logic     busy,
    output logic     done,
    output cmp_res_t res
);

    localparam int CNT_W = $clog2(FULL_LAT + 1);
    localparam logic [CNT_W-1:0] FAST_LAST = CNT_W'(FAST_LAT - 1);
    localparam logic [CNT_W-1:0] FULL_LAST = CNT_W'(FULL_LAT - 1);

    typedef struct packed {
        logic             busy;
        logic [CNT_W-1:0] cnt;
        logic             done;
        cmp_res_t         res;
    } ctrl_st_t;

    ctrl_st_t st_d, st_q;
    logic     take_fast_d;
    logic     full_end_d;

    always_comb begin
        st_d        = st_q;
        st_d.done   = 1'b0;
        take_fast_d = st_q.busy && !mode_mag && low_differ && (st_q.cnt == FAST_LAST);
        full_end_d  = st_q.busy && (st_q.cnt == FULL_LAST);
        if (start) begin
            st_d.busy = 1'b1;
            st_d.cnt  = '0;
        end else if (take_fast_d) begin
            st_d.busy = 1'b0;
            st_d.done = 1'b1;
            st_d.res  = '{eq: 1'b0, lt: 1'b0, gt: 1'b0, early: 1'b1};
        end else if (full_end_d) begin
            st_d.busy = 1'b0;
            st_d.done = 1'b1;
            st_d.res  = '{eq: full_eq,
                          lt: mode_mag && full_lt,
                          gt: mode_mag && full_gt,
                          early: 1'b0};
        end else if (st_q.busy) begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '{busy: 1'b0, cnt: '0, done: 1'b0, res: CMP_RES_CLEAR};
        end else begin
            st_q <= st_d;
        end
    end

    assign busy = st_q.busy;
    assign done = st_q.done;
    assign res  = st_q.res;

    // completion is a single-cycle pulse (R6)
    p_done_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.done |=> !st_q.done);

    // a shortcut result carries no ordering and no equality (R3)
    p_fast_flags_r3: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.done && st_q.res.early |-> !st_q.res.eq && !st_q.res.lt && !st_q.res.gt);

    // idle and no new request: flags stay put (R7)
    p_flags_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !start && !st_q.busy |=> $stable(st_q.res));

    // exact latencies for the default timing (R3, R4)
    if (FAST_LAT == 1 && FULL_LAT == 3) begin : g_lat_chk
        p_fast_lat_r3: assert property (@(posedge clk) disable iff (!rst_n)
            st_q.done && st_q.res.early |-> $past(start, 2));
        p_full_lat_r4: assert property (@(posedge clk) disable iff (!rst_n)
            st_q.done && !st_q.res.early |-> $past(start, 4));
    end

endmodule

// File: rtl/early_out_cmp.sv
// Variable-latency unsigned comparator with a low-bit early exit.
module early_out_cmp
    import cmp_pkg::*;
#(
    parameter int DATA_W   = 32,
    parameter int FAST_W   = 4,
    parameter int CHUNK_W  = 8,
    parameter int FAST_LAT = 1,
    parameter int FULL_LAT = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              mag_mode,
    input  logic [DATA_W-1:0] op_a,
    input  logic [DATA_W-1:0] op_b,
    output logic              done,
    output logic              res_eq,
    output logic              res_lt,
    output logic              res_gt,
    output logic              res_early
);

    typedef struct packed {
        logic [DATA_W-1:0] a;
        logic [DATA_W-1:0] b;
        logic              mode;
    } opnd_st_t;

    opnd_st_t opnd_d, opnd_q;
    logic     ctrl_busy;
    logic     accept;
    logic     low_differ;
    logic     full_eq, full_lt, full_gt;
    cmp_res_t res_w;

    assign req_ready = !ctrl_busy;
    assign accept    = req_valid && req_ready;

    always_comb begin
        opnd_d = opnd_q;
        if (accept) begin
            opnd_d.a    = op_a;
            opnd_d.b    = op_b;
            opnd_d.mode = mag_mode;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            opnd_q <= '0;
        end else begin
            opnd_q <= opnd_d;
        end
    end

    cmp_fast_diff #(.FAST_W(FAST_W)) u_fast (
        .lo_a   (opnd_q.a[FAST_W-1:0]),
        .lo_b   (opnd_q.b[FAST_W-1:0]),
        .differ (low_differ)
    );

    cmp_full_mag #(.DATA_W(DATA_W), .CHUNK_W(CHUNK_W)) u_full (
        .clk    (clk),
        .rst_n  (rst_n),
        .full_a (opnd_q.a),
        .full_b (opnd_q.b),
        .is_eq  (full_eq),
        .is_lt  (full_lt),
        .is_gt  (full_gt)
    );

    cmp_seq_ctrl #(.FAST_LAT(FAST_LAT), .FULL_LAT(FULL_LAT)) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (accept),
        .mode_mag   (opnd_q.mode),
        .low_differ (low_differ),
        .full_eq    (full_eq),
        .full_lt    (full_lt),
        .full_gt    (full_gt),
        .busy       (ctrl_busy),
        .done       (done),
        .res        (res_w)
    );

    assign res_eq    = res_w.eq;
    assign res_lt    = res_w.lt;
    assign res_gt    = res_w.gt;
    assign res_early = res_w.early;

    // an accepted request makes the block busy on the next cycle (R2)
    p_busy_after_accept_r2: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> !req_ready);

    // magnitude requests never leave through the shortcut (R5)
    p_mag_no_early_r5: assert property (@(posedge clk) disable iff (!rst_n)
        done && opnd_q.mode |-> !res_early);

    // at most one ordering flag in any result (R5)
    p_flag_count_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({res_eq, res_lt, res_gt}) <= 1);

endmodule

// File: tb/test_early_out_cmp.sv
module test_early_out_cmp;

    localparam int DW = 32;

    typedef struct {
        logic  eq;
        logic  lt;
        logic  gt;
        logic  early;
        int    lat;
        int    acc;
        string tag;
    } exp_t;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic          req_ready;
    logic          mag_mode = 1'b0;
    logic [DW-1:0] op_a = '0;
    logic [DW-1:0] op_b = '0;
    logic          done;
    logic          res_eq, res_lt, res_gt, res_early;

    int   n_checks = 0;
    int   n_fail   = 0;
    int   cyc      = 0;
    exp_t sb_q[$];
    int   done_cycs[$];
    logic [3:0] last_flags = 4'b0;
    bit   noisy = 1'b0;

    always #10 clk = ~clk;   // 50 MHz
    always @(posedge clk) cyc <= cyc + 1;

    early_out_cmp i_early_out_cmp (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .mag_mode(mag_mode), .op_a(op_a), .op_b(op_b), .done(done),
        .res_eq(res_eq), .res_lt(res_lt), .res_gt(res_gt), .res_early(res_early)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // driver: waits for ready, drives one request and pushes its expected result
    task automatic issue(input logic [DW-1:0] a, input logic [DW-1:0] b,
                         input logic mag, input string tag);
        exp_t e;
        @(negedge clk);
        while (!req_ready) begin
            if (noisy) begin
                req_valid = 1'b1;
                op_a      = $urandom;
                op_b      = $urandom;
                mag_mode  = $urandom_range(0, 1);
            end else begin
                req_valid = 1'b0;
            end
            @(negedge clk);
        end
        req_valid = 1'b1;
        op_a      = a;
        op_b      = b;
        mag_mode  = mag;
        e.early = !mag && (a[3:0] != b[3:0]);
        e.eq    = !e.early && (a == b);
        e.lt    = mag && (a < b);
        e.gt    = mag && (a > b);
        e.lat   = e.early ? 1 : 3;
        e.acc   = cyc + 1;
        e.tag   = tag;
        sb_q.push_back(e);
    endtask

    task automatic idle_bus();
        @(negedge clk);
        while (!req_ready) begin
            req_valid = noisy;
            @(negedge clk);
        end
        req_valid = 1'b0;
        noisy     = 1'b0;
        repeat (5) @(negedge clk);
    endtask

    // monitor: compares each completion against the scoreboard
    initial begin
        forever begin
            @(negedge clk);
            if (rst_n) begin
                if (done) begin
                    if (sb_q.size() == 0) begin
                        check(1'b0, "R6/R2", "done without pending request", 1, 0);
                    end else begin
                        exp_t e;
                        e = sb_q.pop_front();
                        check({res_eq, res_lt, res_gt, res_early} == {e.eq, e.lt, e.gt, e.early},
                              e.tag, "flags eq/lt/gt/early",
                              int'({res_eq, res_lt, res_gt, res_early}),
                              int'({e.eq, e.lt, e.gt, e.early}));
                        check(cyc - e.acc == e.lat, e.tag, "latency", cyc - e.acc, e.lat);
                    end
                    done_cycs.push_back(cyc);
                    last_flags = {res_eq, res_lt, res_gt, res_early};
                end else begin
                    check({res_eq, res_lt, res_gt, res_early} == last_flags, "R7",
                          "flags held", int'({res_eq, res_lt, res_gt, res_early}),
                          int'(last_flags));
                end
            end
        end
    end

    // watchdog
    initial begin
        wait (cyc > 100000);
        check(1'b0, "WATCHDOG", "run did not finish", cyc, 100000);
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        int gap;
        // R1: reset state
        repeat (3) @(negedge clk);
        check(!done && req_ready, "R1", "done/ready in reset",
              int'({done, req_ready}), 1);
        check({res_eq, res_lt, res_gt, res_early} == 4'b0, "R1", "flags in reset",
              int'({res_eq, res_lt, res_gt, res_early}), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(!done && req_ready, "R1", "done/ready after reset",
              int'({done, req_ready}), 1);

        // R3: equality mode, low nibble differs only
        issue(32'h1234_5670, 32'h1234_5671, 1'b0, "R3");
        issue(32'h0000_000f, 32'h0000_0000, 1'b0, "R3");
        issue(32'hffff_fff8, 32'h0000_0007, 1'b0, "R3");
        // R4: equality mode, low nibble equal
        issue(32'h8000_0005, 32'h0000_0005, 1'b0, "R4");
        issue(32'h0000_0010, 32'h0000_0000, 1'b0, "R4");
        issue(32'hdead_beef, 32'hdead_beef, 1'b0, "R4");
        // R5: magnitude mode, low-only and high-only differences, equal
        issue(32'h0000_0003, 32'h0000_0004, 1'b1, "R5");
        issue(32'h0000_0100, 32'h0000_0000, 1'b1, "R5");
        issue(32'h5555_5555, 32'h5555_5555, 1'b1, "R5");
        // R9: unsigned ordering with bit 31
        issue(32'h8000_0000, 32'h7fff_ffff, 1'b1, "R9");
        issue(32'h7fff_ffff, 32'hffff_ffff, 1'b1, "R9");
        idle_bus();

        // R8: back-to-back fast pair and full pair
        issue(32'h1, 32'h2, 1'b0, "R8");
        issue(32'h3, 32'h4, 1'b0, "R8");
        idle_bus();
        gap = done_cycs[$] - done_cycs[$-1];
        check(gap == 2, "R8", "fast back-to-back gap", gap, 2);
        issue(32'h10, 32'h20, 1'b1, "R8");
        issue(32'h30, 32'h40, 1'b0, "R8");
        idle_bus();
        gap = done_cycs[$] - done_cycs[$-1];
        check(gap == 4, "R8", "full back-to-back gap", gap, 4);

        // R2: requests held while busy must be ignored
        noisy = 1'b1;
        issue(32'h0000_1000, 32'h0000_2000, 1'b0, "R2");
        issue(32'h0000_0009, 32'h0000_0001, 1'b1, "R2");
        issue(32'h0000_0002, 32'h0000_0003, 1'b0, "R2");
        idle_bus();
        check(sb_q.size() == 0, "R6", "pending after noisy run", sb_q.size(), 0);

        // random mix, some sharing high or low bits
        for (int i = 0; i < 300; i++) begin
            logic [DW-1:0] a, b;
            a = $urandom;
            case (i % 3)
                0: b = $urandom;
                1: b = {a[DW-1:4], 4'($urandom)};
                default: b = {32'($urandom) & 32'hffff_fff0} | {28'h0, a[3:0]};
            endcase
            noisy = (i % 7 == 0);
            issue(a, b, 1'($urandom_range(0, 1)), "R3/R4/R5");
        end
        idle_bus();
        check(sb_q.size() == 0, "R6", "pending at end", sb_q.size(), 0);

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule